// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. Software picks a channel and a conversion clock rate, turns the conversion clock on, and then writes a start strobe. The sequencer waits for the next conversion-clock tick to line the request up with that clock. It then holds the sample phase for a fixed number of ticks and latches the channel number for the analog mux. After that it drives a trial code to the DAC one bit at a time, MSB first, and uses a comparator bit to decide whether to keep each bit.

When all bit trials are done and a short settling interval has passed, the code is loaded into the result register. In the same cycle a one-cycle completion strobe is raised and the busy flag drops. The conversion clock is an enable derived from the system clock by a power-of-two prescaler. Its rate is selected through a small select input.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, busy, done, sample_en, dac_code and result are all 0.
- R2: A start write is accepted only when clk_on is 1 and the block is idle. A start write made while clk_on is 0 leaves busy at 0.
- R3: The conversion tick period D is 2^clk_sel system cycles. sample_en rises between 1 and D cycles after the cycle in which the start write is accepted.
- R4: sample_en stays high for exactly 8·D cycles.
- R5: done appears exactly 21·D cycles after sample_en rises.
- R6: The result follows the bit trials, MSB first. A trial bit is kept when comp_in is 1, meaning the input is greater than or equal to dac_code. With an ideal comparator, the result equals the input code.
- R7: When sampling ends, dac_code shows the first trial, which is only the MSB set (512 for 10 bits).
- R8: busy is 1 from the cycle after an accepted start until the result load. A start write made while busy is 1, including one on the cycle of the result load, is ignored and does not restart or lengthen the conversion.
- R9: ch_out takes the value of ch_sel when sampling starts. Changing ch_sel later in the conversion does not change ch_out.
- R10: done is high for a single cycle. result changes only together with done and holds its value until the next completion.
- R11: A start write made in the cycle where done is high is accepted, because busy is already 0, and it begins a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_on | input | 1 | Enables the conversion-clock prescaler |
| clk_sel | input | SEL_W | Conversion tick period select, D = 2^clk_sel |
| ch_sel | input | CH_W | Channel to convert, latched when sampling starts |
| start_wr | input | 1 | One-cycle software start strobe |
| comp_in | input | 1 | Comparator output, 1 when the input is greater than or equal to dac_code |
| dac_code | output | RES_W | Current trial code driven to the DAC |
| sample_en | output | 1 | High during the sampling phase |
| ch_out | output | CH_W | Latched channel number for the analog mux |
| busy | output | 1 | Conversion in progress |
| result | output | RES_W | Last completed conversion code |
| done | output | 1 | One-cycle completion strobe |

## Verification
Two events can fall in the same cycle: the result load and a software start write. The bench sets up both orderings in every run. It drives a start write one cycle before done becomes visible, so the write meets the load edge while busy is still 1. It must then see busy low and result unchanged on the following cycle, with no restart. In chained runs it holds the write through the cycle where done is high, and it expects busy to be 1 on the next cycle. It also expects the next conversion to meet the same sync, sampling and total-time windows.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;

  // Conversion tick period in system cycles for a given select value.
  function automatic int unsigned div_of(input int unsigned sel);
    return 32'd1 << sel;
  endfunction

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen import sar_seq_pkg::*; #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_on,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limit;

  assign limit = PRE_W'(div_of(32'(clk_sel)) - 1);
  // Uses >= so that shrinking the period mid-count cannot hang the tick.
  assign tick  = clk_on && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!clk_on) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sar_step_ctrl.sv
module sar_step_ctrl import sar_seq_pkg::*; #(
  parameter int RES_W = 10,
  parameter int SAMP  = 8,
  parameter int TOTAL = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clk_on,
  input  logic start_wr,
  output logic busy,
  output logic sample_en,
  output logic sample_start,
  output logic trial_start,
  output logic trial_eval,
  output logic load_evt
);
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] C_SAMP  = CNT_W'(SAMP);
  localparam logic [CNT_W-1:0] C_EVEND = CNT_W'(SAMP + RES_W);
  localparam logic [CNT_W-1:0] C_TOTAL = CNT_W'(TOTAL);

  seq_state_e       state_q;
  logic [CNT_W-1:0] tcnt_q;
  logic [CNT_W-1:0] nxt;
  logic             accept;
  logic             run_tick;

  assign accept       = start_wr && clk_on && (state_q == SEQ_IDLE);
  assign nxt          = tcnt_q + 1'b1;
  assign sample_start = (state_q == SEQ_WAIT) && tick;
  assign run_tick     = (state_q == SEQ_RUN) && tick;
  assign trial_start  = run_tick && (nxt == C_SAMP);
  assign trial_eval   = run_tick && (nxt > C_SAMP) && (nxt <= C_EVEND);
  assign load_evt     = run_tick && (nxt == C_TOTAL);
  assign busy         = (state_q != SEQ_IDLE);
  assign sample_en    = (state_q == SEQ_RUN) && (tcnt_q < C_SAMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      tcnt_q  <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (accept) state_q <= SEQ_WAIT;
        SEQ_WAIT: if (tick) begin
          state_q <= SEQ_RUN;
          tcnt_q  <= '0;
        end
        SEQ_RUN: if (tick) begin
          if (load_evt) begin
            state_q <= SEQ_IDLE;
            tcnt_q  <= '0;
          end else begin
            tcnt_q <= nxt;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trial_start,
  input  logic             trial_eval,
  input  logic             load_evt,
  input  logic             comp_in,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] trial_ptr,
  output logic [RES_W-1:0] result,
  output logic             done
);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  // Keep or drop the bit under test, then raise the next lower trial bit.
  function automatic logic [RES_W-1:0] sar_next(input logic [RES_W-1:0] code,
                                                input logic [RES_W-1:0] ptr,
                                                input logic             keep);
    logic [RES_W-1:0] kept;
    kept = keep ? code : (code & ~ptr);
    return kept | (ptr >> 1);
  endfunction

  logic [RES_W-1:0] code_q;
  logic [RES_W-1:0] ptr_q;

  assign dac_code  = code_q;
  assign trial_ptr = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ptr_q  <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= load_evt;
      if (trial_start) begin
        code_q <= MSB_ONLY;
        ptr_q  <= MSB_ONLY;
      end else if (trial_eval) begin
        code_q <= sar_next(code_q, ptr_q, comp_in);
        ptr_q  <= ptr_q >> 1;
      end
      if (load_evt) result <= code_q;
    end
  end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq import sar_seq_pkg::*; #(
  parameter int RES_W = 10,
  parameter int CH_W  = 3,
  parameter int SEL_W = 2,
  parameter int SAMP  = 8,
  parameter int TOTAL = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_on,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [CH_W-1:0]  ch_sel,
  input  logic             start_wr,
  input  logic             comp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             sample_en,
  output logic [CH_W-1:0]  ch_out,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             done
);
  logic             tick;
  logic             sample_start;
  logic             trial_start;
  logic             trial_eval;
  logic             load_evt;
  logic [RES_W-1:0] trial_ptr;

  sar_tick_gen #(.SEL_W(SEL_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .clk_on(clk_on), .clk_sel(clk_sel), .tick(tick)
  );

  sar_step_ctrl #(.RES_W(RES_W), .SAMP(SAMP), .TOTAL(TOTAL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clk_on(clk_on), .start_wr(start_wr),
    .busy(busy), .sample_en(sample_en), .sample_start(sample_start),
    .trial_start(trial_start), .trial_eval(trial_eval), .load_evt(load_evt)
  );

  sar_approx_reg #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .trial_start(trial_start), .trial_eval(trial_eval),
    .load_evt(load_evt), .comp_in(comp_in), .dac_code(dac_code),
    .trial_ptr(trial_ptr), .result(result), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ch_out <= '0;
    else if (sample_start) ch_out <= ch_sel;
  end
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
  parameter int RES_W = 10,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_on,
  input logic             start_wr,
  input logic             busy,
  input logic             done,
  input logic             sample_en,
  input logic             sample_start,
  input logic             load_evt,
  input logic [RES_W-1:0] trial_ptr,
  input logic [RES_W-1:0] result,
  input logic [CH_W-1:0]  ch_out
);
  // R2
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_wr && clk_on));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load_evt) |=> busy);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  // R9
  ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_out) |-> $past(sample_start));

  // R4
  sample_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> busy);

  // R6
  ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trial_ptr));
endmodule

bind sar_adc_seq sar_adc_seq_chk #(.RES_W(RES_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_on(clk_on), .start_wr(start_wr), .busy(busy),
  .done(done), .sample_en(sample_en), .sample_start(sample_start),
  .load_evt(load_evt), .trial_ptr(trial_ptr), .result(result), .ch_out(ch_out)
);

// File: tb/sar_adc_seq_tb_top.sv
`timescale 1ns/1ps
module sar_adc_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_on = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic [2:0] ch_sel = 3'd0;
  logic       start_wr = 1'b0;
  logic       comp_in;
  logic [9:0] dac_code;
  logic       sample_en;
  logic [2:0] ch_out;
  logic       busy;
  logic [9:0] result;
  logic       done;
  logic [9:0] target = 10'd0;

  int total_chk = 0;
  int fail_chk  = 0;

  always #5 clk = ~clk;

  // Ideal comparator: 1 when the held input is at or above the DAC level.
  assign comp_in = (target >= dac_code);

  sar_adc_seq dut_i (
    .clk(clk), .rst_n(rst_n), .clk_on(clk_on), .clk_sel(clk_sel), .ch_sel(ch_sel),
    .start_wr(start_wr), .comp_in(comp_in), .dac_code(dac_code),
    .sample_en(sample_en), .ch_out(ch_out), .busy(busy), .result(result), .done(done)
  );

  function automatic logic [9:0] exp_code(input logic [9:0] tgt);
    logic [9:0] acc = '0;
    for (int b = 9; b >= 0; b--) begin
      logic [9:0] trial = acc | (10'd1 << b);
      if (tgt >= trial) acc = trial;
    end
    return acc;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total_chk++;
    if (!ok) begin
      fail_chk++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_conv(input logic [9:0] tgt, input logic [1:0] sel,
                          input logic [2:0] ch, input bit do_start, input bit chain);
    int d;
    int n = 0;
    int ns = -1;
    int nd = -1;
    int scount = 0;
    logic [2:0] ch_exp;
    logic [9:0] held;
    target = tgt;
    if (do_start) begin
      clk_on = 1'b1; clk_sel = sel; ch_sel = ch; start_wr = 1'b1;
      ch_exp = ch;
    end else begin
      ch_exp = ch_sel;
    end
    d = 1 << clk_sel;
    @(negedge clk);
    start_wr = 1'b0;
    chk(busy == 1'b1, "R8/R11 busy after accepted start", int'(busy), 1);
    while (nd < 0 && n < 4000) begin
      @(negedge clk);
      n++;
      if (sample_en) scount++;
      if (ns < 0 && sample_en) ns = n;
      if (ns >= 0) begin
        if (n == ns + 2) ch_sel = ~ch_exp;
        if (n == ns + 3) start_wr = 1'b1;
        if (n == ns + 4) start_wr = 1'b0;
        if (n == ns + 8*d)
          chk(dac_code == 10'd512, "R7 first trial code", int'(dac_code), 512);
        if (n == ns + 21*d - 1) start_wr = 1'b1;
      end
      if (done) nd = n;
    end
    if (nd < 0) begin
      chk(1'b0, "R5 conversion never completed", n, 21*d);
      start_wr = 1'b0;
      return;
    end
    chk(ns >= 1 && ns <= d, "R3 sync delay", ns, d);
    chk(nd - ns == 21*d, "R5 total conversion time", nd - ns, 21*d);
    chk(scount == 8*d, "R4 sampling length", scount, 8*d);
    chk(result == exp_code(tgt), "R6 result code", int'(result), int'(exp_code(tgt)));
    chk(ch_out == ch_exp, "R9 latched channel", int'(ch_out), int'(ch_exp));
    chk(busy == 1'b0, "R8 busy clear at load", int'(busy), 0);
    if (chain) return;
    start_wr = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
    chk(busy == 1'b0, "R8 start on load edge ignored", int'(busy), 0);
    held = result;
    repeat (3) @(negedge clk);
    chk(result == held, "R10 result holds", int'(result), int'(held));
  endtask

  initial begin
    #(200000 * 10);
    fail_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total_chk, fail_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done reset", int'(done), 0);
    chk(sample_en == 1'b0, "R1 sample_en reset", int'(sample_en), 0);
    chk(dac_code == 10'd0, "R1 dac reset", int'(dac_code), 0);
    chk(result == 10'd0, "R1 result reset", int'(result), 0);

    // R2: start with the conversion clock off is ignored
    clk_on = 1'b0; start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R2 start with clock off", int'(busy), 0);
    clk_on = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R2 no late start after clock on", int'(busy), 0);

    // Directed corner codes and rates
    run_conv(10'd0,    2'd0, 3'd1, 1'b1, 1'b0);
    run_conv(10'd1023, 2'd3, 3'd6, 1'b1, 1'b0);
    run_conv(10'd512,  2'd1, 3'd2, 1'b1, 1'b0);
    run_conv(10'd511,  2'd2, 3'd5, 1'b1, 1'b0);
    // R11: start written in the done cycle chains into a new conversion
    run_conv(10'd300,  2'd1, 3'd4, 1'b1, 1'b1);
    run_conv(10'd700,  2'd1, 3'd0, 1'b0, 1'b0);

    for (int i = 0; i < 16; i++) begin
      logic [9:0] t = 10'($urandom_range(0, 1023));
      logic [1:0] s = 2'($urandom_range(0, 3));
      logic [2:0] c = 3'($urandom_range(0, 7));
      run_conv(t, s, c, 1'b1, 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total_chk, fail_chk);
    $finish;
  end
endmodule